// File: doc/BRIEF.md
# Privileged Trap Entry Sequencer

This block steers a simple 64-bit in-order core into a privileged handler mode and back out again. A trap arrives as a fault code with a strobe, together with the PC of the instruction being executed. The block then produces a redirect to a handler vector, which is the live handler-base value plus a fixed offset chosen by the fault code. It also records a restart address and, when the core was not already in handler mode, makes a set of shadow registers visible. A handler-return strobe sends the core back to the saved restart address. Bit 0 of that address decides whether the normal registers come back into view.

Handler mode is marked by bit 0 of the PC. The block holds the core's integer register file, with one write port and one read port. Eight of the registers have shadow copies. Entering or leaving the handler flips a single bank-select bit, so nothing is copied and the read port always sees the selected bank. A request to switch to the bank that is already selected is illegal: it is refused and raises a sticky error flag.

All outputs are registered, and a redirect appears one clock after the strobe that caused it.

Top module: `priv_trap_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is as follows: `shadow_sel`=1, `redir_pc`=`hbase`+0x0001, `redir_npc`=`redir_pc`+4, `exc_addr`=0, `swap_err`=0, `redir_valid`=0, and every register reads 0.
- R2: An accepted trap sets `redir_valid` for one cycle, one clock later. In that cycle `redir_pc`=`hbase`+offset and `redir_npc`=`redir_pc`+4. The offsets by `trap_code` are: 1→0x0001, 2→0x0401, 3→0x0501, 4→0x0101, 5→0x0201, 6→0x0281, 7→0x0301, 8 and 9→0x0381, 10 and 11→0x0181, 12→0x0081, 13→0x0481, 14→0x0581, 15→0x2001, 16→0x0501.
- R3: An accepted trap loads `exc_addr` from `cur_pc`. The one exception is code 4 (interrupt) while `cur_pc[0]`=1, which leaves `exc_addr` unchanged.
- R4: For code 15 (privileged call) and code 3 (arithmetic), the saved address is `cur_pc`+4.
- R5: A trap taken with `cur_pc[0]`=0 selects the shadow bank (`shadow_sel`=1). A trap taken with `cur_pc[0]`=1 leaves the bank select unchanged.
- R6: A return (`hret`) with `cur_pc[0]`=1 redirects to the current `exc_addr`, with `redir_npc` equal to that address plus 4. It selects the normal bank only if `exc_addr[0]`=0; otherwise the bank select is unchanged.
- R7: A return with `cur_pc[0]`=0 behaves exactly as an accepted trap with code 13 (unimplemented opcode).
- R8: A swap towards the bank that is already selected leaves `shadow_sel` unchanged and sets `swap_err`. `swap_err` then stays at 1 until reset.
- R9: If an accepted trap and `hret` arrive in the same cycle, the trap is taken and the return is ignored.
- R10: A `trap_valid` strobe carrying code 0 or a code above 16 has no effect. With `hret` low, `redir_valid` stays 0 and `exc_addr`, `redir_pc` and `shadow_sel` are unchanged.
- R11: Only registers 8 to 14 and register 25 have a shadow copy; all others are shared by both banks. A write uses the bank selected before the clock edge, even when a swap happens at that same edge, and `rd_data` reads the bank currently selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | Fault strobe |
| trap_code | input | 5 | Fault code (see R2) |
| cur_pc | input | 64 | PC of the current instruction; bit 0 marks handler mode |
| hret | input | 1 | Handler-return strobe |
| hbase | input | 64 | Handler base address |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Register write index |
| wr_data | input | 64 | Register write data |
| rd_idx | input | 5 | Register read index |
| rd_data | output | 64 | Register read data from the selected bank |
| redir_valid | output | 1 | Redirect issued this cycle |
| redir_pc | output | 64 | Redirected PC |
| redir_npc | output | 64 | Redirected PC plus 4 |
| exc_addr | output | 64 | Saved restart address |
| shadow_sel | output | 1 | 1 when the shadow bank is selected |
| swap_err | output | 1 | Sticky flag for an illegal bank swap |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a trap strobe together with a return strobe. The second is a register write together with the bank flip caused by a trap. The bench drives a valid trap and `hret` at the same edge and expects the trap's vector and bank change, with no trace of the return. It also writes a shadowed register in the very cycle that a trap selects the shadow bank. It then reads that register once under each bank, expecting the new value only in the normal bank. A behavioural model written with arrays and integers is compared against every output on every clock.

// File: rtl/trap_seq_pkg.sv
// Shared types and constants for the privileged trap sequencer.
// Assumes a 32-entry integer file; the shadowed set is fixed.
package trap_seq_pkg;

    typedef enum logic [4:0] {
        TC_NONE    = 5'd0,
        TC_RESET   = 5'd1,
        TC_MCHK    = 5'd2,
        TC_ARITH   = 5'd3,
        TC_INTR    = 5'd4,
        TC_DMISS_N = 5'd5,
        TC_DMISS_H = 5'd6,
        TC_ALIGN   = 5'd7,
        TC_DFAULT  = 5'd8,
        TC_DACV    = 5'd9,
        TC_IMISS   = 5'd10,
        TC_IFAULT  = 5'd11,
        TC_IACV    = 5'd12,
        TC_UNIMP   = 5'd13,
        TC_FPDIS   = 5'd14,
        TC_PRIV    = 5'd15,
        TC_IOVF    = 5'd16
    } tcode_e;

    localparam int          NSHD      = 8;
    localparam int          OFS_W     = 16;
    localparam logic [15:0] RESET_OFS = 16'h0001;
    localparam int          STEP      = 4;

    // True when the code is one the sequencer accepts
    function automatic logic code_known(input logic [4:0] c);
        return (c >= 5'd1) && (c <= 5'd16);
    endfunction

    // True when the register index has a shadow copy
    function automatic logic banked(input int idx);
        return ((idx >= 8) && (idx <= 14)) || (idx == 25);
    endfunction

    // Shadow slot that holds a banked register
    function automatic logic [2:0] slot(input int idx);
        return (idx == 25) ? 3'd7 : 3'(idx - 8);
    endfunction

endpackage

// File: rtl/trp_vec_lut.sv
// Fault-code to vector-offset lookup, plus the skip-instruction flag.
// Assumes the code has already been qualified as known.
module trp_vec_lut
    import trap_seq_pkg::*;
(
    input  tcode_e             code,
    output logic [OFS_W-1:0]   ofs,
    output logic               skip
);

    // Map each code to its handler offset
    always_comb begin
        case (code)
            TC_RESET:             ofs = 16'h0001;
            TC_MCHK:              ofs = 16'h0401;
            TC_ARITH, TC_IOVF:    ofs = 16'h0501;
            TC_INTR:              ofs = 16'h0101;
            TC_DMISS_N:           ofs = 16'h0201;
            TC_DMISS_H:           ofs = 16'h0281;
            TC_ALIGN:             ofs = 16'h0301;
            TC_DFAULT, TC_DACV:   ofs = 16'h0381;
            TC_IMISS, TC_IFAULT:  ofs = 16'h0181;
            TC_IACV:              ofs = 16'h0081;
            TC_UNIMP:             ofs = 16'h0481;
            TC_FPDIS:             ofs = 16'h0581;
            TC_PRIV:              ofs = 16'h2001;
            default:              ofs = 16'h0000;
        endcase
    end

    // Trap-type faults resume after the trapping instruction
    assign skip = (code == TC_PRIV) || (code == TC_ARITH);

endmodule

// File: rtl/trp_bank_ctl.sv
// Bank-select flop with a sticky error for redundant swap requests.
// Assumes at most one swap request per cycle; resets to the shadow bank.
module trp_bank_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic req_bank,
    output logic bank_sel,
    output logic swap_err
);

    logic bank_q, err_q;

    // Flip the bank on a legal request, flag an illegal one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b1;
            err_q  <= 1'b0;
        end else if (swap_req) begin
            if (req_bank == bank_q) err_q  <= 1'b1;
            else                    bank_q <= req_bank;
        end
    end

    assign bank_sel = bank_q;
    assign swap_err = err_q;

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R8
    bad_swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && (req_bank == bank_q)) |=> ($stable(bank_q) && err_q));

endmodule

// File: rtl/trp_bank_rf.sv
// Integer register file with shadow copies of a fixed register subset.
// Assumes bank_sel is the select in force before the clock edge.
module trp_bank_rf
    import trap_seq_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bank_sel,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_data
);

    logic [XLEN-1:0] gpr_q [NREG];
    logic [XLEN-1:0] shd_q [NSHD];
    logic [NREG-1:0] bmask;

    // Constant mask of registers that own a shadow copy
    for (genvar g = 0; g < NREG; g++) begin : g_mask
        assign bmask[g] = banked(g);
    end

    logic wr_shd, rd_shd;
    assign wr_shd = bank_sel && bmask[wr_idx];
    assign rd_shd = bank_sel && bmask[rd_idx];

    // Store a write into the bank selected before this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) gpr_q[i] <= '0;
            for (int i = 0; i < NSHD; i++) shd_q[i] <= '0;
        end else if (wr_en) begin
            if (wr_shd) shd_q[slot(int'(wr_idx))] <= wr_data;
            else        gpr_q[wr_idx]             <= wr_data;
        end
    end

    // Read through the currently selected bank
    assign rd_data = rd_shd ? shd_q[slot(int'(rd_idx))] : gpr_q[rd_idx];

endmodule

// File: rtl/priv_trap_seq.sv
// Trap entry / handler return sequencer with shadow register bank.
// Assumes handler mode is PC bit 0 and all outputs are registered.
module priv_trap_seq
    import trap_seq_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid,
    input  logic [4:0]      trap_code,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            hret,
    input  logic [XLEN-1:0] hbase,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_data,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output logic [XLEN-1:0] redir_npc,
    output logic [XLEN-1:0] exc_addr,
    output logic            shadow_sel,
    output logic            swap_err
);

    logic            trap_ok, ret_ok, eff_trap, in_h;
    tcode_e          eff_code;
    logic [OFS_W-1:0] ofs;
    logic            skip;
    logic            swap_req, req_bank;
    logic [XLEN-1:0] pc_q, npc_q, exc_q, nxt_pc, nxt_exc;
    logic            valid_q;

    // Qualify strobes: a trap outranks a return
    assign trap_ok  = trap_valid && code_known(trap_code);
    assign ret_ok   = hret && !trap_ok;
    assign in_h     = cur_pc[0];
    assign eff_trap = trap_ok || (ret_ok && !in_h);
    assign eff_code = trap_ok ? tcode_e'(trap_code) : TC_UNIMP;

    trp_vec_lut u_lut (
        .code (eff_code),
        .ofs  (ofs),
        .skip (skip)
    );

    // Work out the next redirect, restart address and swap request
    always_comb begin
        nxt_pc   = pc_q;
        nxt_exc  = exc_q;
        swap_req = 1'b0;
        req_bank = 1'b0;
        if (eff_trap) begin
            if (!((eff_code == TC_INTR) && in_h))
                nxt_exc = cur_pc + (skip ? XLEN'(STEP) : '0);
            if (!in_h) begin
                swap_req = 1'b1;
                req_bank = 1'b1;
            end
            nxt_pc = hbase + XLEN'(ofs);
        end else if (ret_ok) begin
            nxt_pc = exc_q;
            if (!exc_q[0]) begin
                swap_req = 1'b1;
                req_bank = 1'b0;
            end
        end
    end

    // Register redirect and restart state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= hbase + XLEN'(RESET_OFS);
            npc_q   <= hbase + XLEN'(RESET_OFS) + XLEN'(STEP);
            exc_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= eff_trap || ret_ok;
            exc_q   <= nxt_exc;
            if (eff_trap || ret_ok) begin
                pc_q  <= nxt_pc;
                npc_q <= nxt_pc + XLEN'(STEP);
            end
        end
    end

    trp_bank_ctl u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_req (swap_req),
        .req_bank (req_bank),
        .bank_sel (shadow_sel),
        .swap_err (swap_err)
    );

    trp_bank_rf #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_sel (shadow_sel),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

    assign redir_valid = valid_q;
    assign redir_pc    = pc_q;
    assign redir_npc   = npc_q;
    assign exc_addr    = exc_q;

    // R3
    intr_keep_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_trap && (eff_code == TC_INTR) && in_h) |=> $stable(exc_addr));

    // R5
    enter_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_trap && !in_h && !shadow_sel) |=> shadow_sel);

    // R6
    ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_ok && in_h) |=> (redir_pc == $past(exc_addr)) && redir_valid);

    // R6
    ret_keep_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_ok && in_h && exc_addr[0]) |=> $stable(shadow_sel));

endmodule

// File: tb/tb_priv_trap_seq.sv
`timescale 1ns/1ps
module tb_priv_trap_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_valid, hret, wr_en;
    logic [4:0]  trap_code, wr_idx, rd_idx;
    logic [63:0] cur_pc, hbase, wr_data;
    logic [63:0] rd_data, redir_pc, redir_npc, exc_addr;
    logic        redir_valid, shadow_sel, swap_err;

    priv_trap_seq dut (.*);

    always #10 clk = ~clk;

    int    checks = 0;
    int    errs   = 0;
    bit    done   = 0;
    string phase  = "R1 reset";

    // Behavioural reference state
    logic [63:0] m_gpr [32];
    logic [63:0] m_shd [8];
    logic [63:0] m_pc, m_npc, m_exc;
    bit          m_bank, m_err, m_valid;

    function automatic logic [63:0] m_ofs(int c);
        case (c)
            1: return 64'h0001;   2: return 64'h0401;   3: return 64'h0501;
            4: return 64'h0101;   5: return 64'h0201;   6: return 64'h0281;
            7: return 64'h0301;   8: return 64'h0381;   9: return 64'h0381;
            10: return 64'h0181;  11: return 64'h0181;  12: return 64'h0081;
            13: return 64'h0481;  14: return 64'h0581;  15: return 64'h2001;
            16: return 64'h0501;  default: return 64'h0;
        endcase
    endfunction

    function automatic int m_slot(int i);
        if (i >= 8 && i <= 14) return i - 8;
        if (i == 25) return 7;
        return -1;
    endfunction

    task automatic m_swap(bit to);
        if (m_bank == to) m_err = 1;
        else m_bank = to;
    endtask

    task automatic m_trap(int c);
        bit inh = cur_pc[0];
        if (!(c == 4 && inh)) m_exc = cur_pc + ((c == 3 || c == 15) ? 64'd4 : 64'd0);
        if (!inh) m_swap(1);
        m_pc = hbase + m_ofs(c);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_gpr[i] = 0;
            for (int i = 0; i < 8; i++)  m_shd[i] = 0;
            m_pc = hbase + 1; m_npc = m_pc + 4; m_exc = 0;
            m_bank = 1; m_err = 0; m_valid = 0;
        end else begin
            bit tv;
            if (wr_en) begin
                if (m_bank && m_slot(int'(wr_idx)) >= 0) m_shd[m_slot(int'(wr_idx))] = wr_data;
                else m_gpr[wr_idx] = wr_data;
            end
            tv = trap_valid && trap_code >= 1 && trap_code <= 16;
            m_valid = tv || hret;
            if (tv) m_trap(int'(trap_code));
            else if (hret) begin
                if (!cur_pc[0]) m_trap(13);
                else begin
                    m_pc = m_exc;
                    if (!m_exc[0]) m_swap(0);
                end
            end
            if (m_valid) m_npc = m_pc + 4;
        end
    end

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    task automatic cmp_all();
        logic [63:0] er;
        er = (m_bank && m_slot(int'(rd_idx)) >= 0) ? m_shd[m_slot(int'(rd_idx))] : m_gpr[rd_idx];
        chk("redir_valid", 64'(redir_valid), 64'(m_valid));
        chk("redir_pc", redir_pc, m_pc);
        chk("redir_npc", redir_npc, m_npc);
        chk("exc_addr", exc_addr, m_exc);
        chk("shadow_sel", 64'(shadow_sel), 64'(m_bank));
        chk("swap_err", 64'(swap_err), 64'(m_err));
        chk("rd_data", rd_data, er);
    endtask

    task automatic tick();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic drive(bit tv, int code, logic [63:0] pc, bit hr);
        trap_valid = tv; trap_code = 5'(code); cur_pc = pc; hret = hr;
        tick();
        trap_valid = 0; hret = 0; wr_en = 0;
    endtask

    task automatic wr(int idx, logic [63:0] d);
        wr_en = 1; wr_idx = 5'(idx); wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic rd(int idx);
        rd_idx = 5'(idx);
        tick();
    endtask

    localparam logic [63:0] ODD = 64'h0000_0000_0010_0101;

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; trap_valid = 0; hret = 0; wr_en = 0;
        trap_code = 0; wr_idx = 0; rd_idx = 0;
        cur_pc = 0; wr_data = 0; hbase = 64'h0000_0000_0010_0000;
        repeat (2) @(negedge clk);
        tick();
        rst_n = 1;
        tick();
        // R1: explicit reset values
        chk("R1 reset pc", redir_pc, 64'h0010_0001);
        chk("R1 reset bank", 64'(shadow_sel), 64'd1);

        phase = "R11 shadow writes";
        for (int i = 0; i < 32; i++) wr(i, 64'hA000 + 64'(i));
        phase = "R6 return to normal";
        drive(1, 0, ODD, 1);       // code 0 ignored, return taken
        drive(0, 0, ODD, 0);
        phase = "R11 normal writes";
        for (int i = 0; i < 32; i++) wr(i, 64'hB000 + 64'(i));
        for (int i = 0; i < 32; i++) rd(i);

        for (int c = 1; c <= 16; c++) begin
            phase = (c == 3 || c == 15) ? "R4 skip" : "R2 R5 vector";
            drive(1, c, 64'h4000 + 64'(c * 16), 0);
            rd(9);
            phase = "R6 return";
            drive(0, 0, ODD, 1);
            rd(25);
        end

        phase = "R3 interrupt in handler";
        drive(1, 2, 64'h5000, 0);
        drive(1, 4, ODD, 0);
        drive(0, 0, ODD, 1);

        phase = "R7 return outside handler";
        drive(0, 0, 64'h6000, 1);
        drive(0, 0, ODD, 1);

        phase = "R9 trap and return together";
        drive(1, 7, 64'h7000, 1);
        drive(0, 0, ODD, 1);

        phase = "R10 unknown codes";
        drive(1, 0, 64'h8000, 0);
        drive(1, 20, 64'h8000, 0);
        drive(1, 31, ODD, 0);

        phase = "R11 write during swap";
        wr_en = 1; wr_idx = 9; wr_data = 64'hC0DE;
        drive(1, 5, 64'h9000, 0);
        rd(9);
        drive(0, 0, ODD, 1);
        rd(9);
        rd(3);

        phase = "R6 odd restart keeps bank";
        drive(1, 2, ODD, 0);
        drive(0, 0, ODD, 1);

        phase = "R8 redundant swap";
        drive(1, 2, 64'hA000, 0);
        drive(0, 0, ODD, 1);
        drive(0, 0, ODD, 1);
        chk("R8 err set", 64'(swap_err), 64'd1);
        drive(1, 12, ODD, 0);
        drive(0, 0, 64'h0, 0);
        phase = "R1 R8 reset clears error";
        rst_n = 0;
        tick();
        rst_n = 1;
        tick();
        chk("R8 err cleared", 64'(swap_err), 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule